// File: doc/BRIEF.md
# Exception Stacking Stack-Limit Guard

This block sits in the exception-entry path of a microcontroller-class core. When entry stacking is requested, it receives the current stack pointer, the kind of frame to push (the basic caller frame or the additional callee-save frame) and the mode bits that decide which stack is in use. It then picks the applicable stack limit and computes the new frame pointer. Before any store is issued it decides whether the push would cross the limit.

If the push would cross the limit, the stack pointer is clamped to the limit, no store is issued at all, and a request is raised to set the overflow status bit of the current security bank and pend a usage fault. If the push fits, the frame words go out one by one, in ascending address order, on a simple valid/ready word-write port. After the last store is accepted, the new stack pointer is reported together with a done pulse.

In parallel, the block screens writes from the secure state to the non-secure state's stack pointer. A value below the selected non-secure limit is refused and raises the same overflow request. A legal value is forwarded as a write strobe. Bus errors on individual stores and the interrupt controller itself live outside this block.

Top module: `stk_guard`

## Requirements
- R1: With `reqCallee`=0 the frame pointer is `curSp`-0x20 and eight words are stored. Word i is `frameWords[32*i +: 32]`, written to frame pointer + 4*i, so word 6 (return PC) lands at offset 24 and word 7 (status) at offset 28.
- R2: With `reqCallee`=1 the frame pointer is `curSp`-0x28 and ten words are stored the same way, so word 2 (r4) lands at offset 0x8 and word 9 (r11) at offset 0x24.
- R3: When no overflow occurs, in the cycle after the last store handshake `spWe`=1, `done`=1, `spNew` equals the frame pointer and `ovfPend`=0.
- R4: When checks are enabled and the frame pointer is below the selected limit (unsigned compare), the following apply in the cycle after acceptance: `spWe`=1, `done`=1, `spNew` equals the limit, `ovfPend`=1 for exactly one cycle and `ovfBank` equals `secureState`. `stValid` is never raised for that request.
- R5: Outside a tail-chained callee push, the process limit `procLimit` is selected exactly when `handlerMode`=0 and `spSel`=1. Otherwise `mainLimit` is selected.
- R6: On a tail-chained callee push (`tailChain`=1 and `reqCallee`=1), the process limit is selected exactly when `retModeThread`=1 and `retSpSelProc`=1. In that case `handlerMode` and `spSel` have no effect.
- R7: Limit checks are enabled only when `v8Profile`=1 and not both `negPriority`=1 and `ignoreOvf`=1. When checks are disabled, a push below the limit proceeds normally.
- R8: A secure (`secureState`=1) write on `otherWrValid` whose value is not below the selected non-secure limit gives, one cycle later, `otherSpWe`=1, `otherSpData` equal to the value and `otherSpProc`=1 exactly when `handlerMode`=0 and `otherSpSel`=1. That same condition selects `otherProcLimit`; otherwise `otherMainLimit` is selected.
- R9: A secure write below the selected non-secure limit produces no `otherSpWe`. One cycle later it gives `ovfPend`=1 with `ovfBank`=1.
- R10: A write on `otherWrValid` while `secureState`=0 is ignored: no `otherSpWe` and no `ovfPend`.
- R11: `busy` is high from acceptance until the done cycle. `stAddr`/`stData` hold while `stValid`=1 and `stReady`=0. `reqValid` while `busy`=1 is ignored.
- R12: When a stacking overflow and a refused other-state write fall in the same cycle, a single one-cycle `ovfPend` pulse results, and both the clamp and the refusal take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start stacking; accepted when not busy |
| reqCallee | input | 1 | 0 = basic frame, 1 = callee-save frame |
| busy | output | 1 | Stacking in progress |
| curSp | input | ADDR_W | Current stack pointer |
| mainLimit | input | ADDR_W | Main stack limit |
| procLimit | input | ADDR_W | Process stack limit |
| handlerMode | input | 1 | Core is in handler mode |
| spSel | input | 1 | Control stack-select bit of current state |
| tailChain | input | 1 | Push is part of a tail-chain |
| retModeThread | input | 1 | Return value mode bit (thread) |
| retSpSelProc | input | 1 | Return value stack-select bit (process) |
| v8Profile | input | 1 | Limit checking profile present |
| negPriority | input | 1 | Execution priority is negative |
| ignoreOvf | input | 1 | Ignore-overflow control bit |
| secureState | input | 1 | Current security state is secure |
| frameWords | input | CALLEE_WORDS*WORD_W | Frame words, word i at bits 32*i |
| stValid | output | 1 | Store request valid |
| stReady | input | 1 | Store accepted |
| stAddr | output | ADDR_W | Store address |
| stData | output | WORD_W | Store data |
| spWe | output | 1 | Stack pointer update strobe |
| spNew | output | ADDR_W | New stack pointer |
| done | output | 1 | Stacking finished |
| otherWrValid | input | 1 | Write to the other state's stack pointer |
| otherWrVal | input | ADDR_W | Value to write |
| otherSpSel | input | 1 | Non-secure control stack-select bit |
| otherMainLimit | input | ADDR_W | Non-secure main stack limit |
| otherProcLimit | input | ADDR_W | Non-secure process stack limit |
| otherSpWe | output | 1 | Other-state stack pointer write strobe |
| otherSpProc | output | 1 | Write targets the process pointer |
| otherSpData | output | ADDR_W | Value written |
| ovfPend | output | 1 | Set overflow status and pend usage fault |
| ovfBank | output | 1 | Security bank of the overflow status |

## Verification
The stacking overflow clamp and the refusal of a secure write to the non-secure stack pointer both drive the single overflow request, and they can land in the same cycle. The bench provokes this by presenting an overflowing stacking request and an out-of-range other-state write on the same clock edge. It expects one `ovfPend` pulse with the secure bank, the stack pointer clamped, and no other-state write. A second case pairs an overflowing push with a legal other-state write. There, the bench expects the write strobe and the fault pulse to appear together.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef struct packed {
    logic capture;  // latch frame pointer, words and length
    logic clamp;    // overflow: report limit as new SP
    logic advance;  // store handshake: next word
    logic finish;   // last store accepted: report frame pointer
    logic pushing;  // store port active
  } stk_strobe_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_PUSH = 1'b1} stk_state_e;
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        overflow,
  input  logic        lastWord,
  input  logic        stReady,
  output stk_strobe_t strobe,
  output logic        busy,
  output logic        stValid
);
  stk_state_e state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          if (overflow) strobe.clamp = 1'b1;
          else          stateNext    = ST_PUSH;
        end
      end
      ST_PUSH: begin
        strobe.pushing = 1'b1;
        if (stReady) begin
          strobe.advance = 1'b1;
          if (lastWord) begin
            strobe.finish = 1'b1;
            stateNext     = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy    = (state == ST_PUSH);
  assign stValid = (state == ST_PUSH);

  // R4: an overflowing request never opens the store port
  assert_no_store_on_ovf_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && overflow) |=> !stValid);

  // R11: a pending store stays offered until accepted
  assert_store_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && !stReady) |=> stValid);
endmodule

// File: rtl/stk_dp.sv
module stk_dp
  import stk_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int WORD_W       = 32,
  parameter int BASIC_WORDS  = 8,
  parameter int CALLEE_WORDS = 10
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  stk_strobe_t                    strobe,
  input  logic                           reqCallee,
  input  logic [ADDR_W-1:0]              curSp,
  input  logic [ADDR_W-1:0]              mainLimit,
  input  logic [ADDR_W-1:0]              procLimit,
  input  logic                           handlerMode,
  input  logic                           spSel,
  input  logic                           tailChain,
  input  logic                           retModeThread,
  input  logic                           retSpSelProc,
  input  logic                           v8Profile,
  input  logic                           negPriority,
  input  logic                           ignoreOvf,
  input  logic                           secureState,
  input  logic [CALLEE_WORDS*WORD_W-1:0] frameWords,
  input  logic                           otherWrValid,
  input  logic [ADDR_W-1:0]              otherWrVal,
  input  logic                           otherSpSel,
  input  logic [ADDR_W-1:0]              otherMainLimit,
  input  logic [ADDR_W-1:0]              otherProcLimit,
  output logic                           overflow,
  output logic                           lastWord,
  output logic [ADDR_W-1:0]              stAddr,
  output logic [WORD_W-1:0]              stData,
  output logic                           spWe,
  output logic [ADDR_W-1:0]              spNew,
  output logic                           done,
  output logic                           otherSpWe,
  output logic                           otherSpProc,
  output logic [ADDR_W-1:0]              otherSpData,
  output logic                           ovfPend,
  output logic                           ovfBank
);
  localparam int WORD_BYTES   = WORD_W / 8;
  localparam int BASIC_BYTES  = BASIC_WORDS * WORD_BYTES;
  localparam int CALLEE_BYTES = CALLEE_WORDS * WORD_BYTES;
  localparam int IDX_W        = $clog2(CALLEE_WORDS);

  logic                                  useProc, checksOn;
  logic [ADDR_W-1:0]                     selLimit, frameBytes, framePtrNext;
  logic [ADDR_W-1:0]                     basePtr;
  logic [IDX_W-1:0]                      idx, lastIdx;
  logic [CALLEE_WORDS-1:0][WORD_W-1:0]   frameReg;
  logic                                  otherUseProc, otherBelow, otherOk, otherBad;
  logic [ADDR_W-1:0]                     otherLim;

  // limit selection (R5, R6) and overflow decision (R4, R7)
  always_comb begin
    if (reqCallee && tailChain) useProc = retModeThread && retSpSelProc;
    else                        useProc = !handlerMode && spSel;
    selLimit     = useProc ? procLimit : mainLimit;
    frameBytes   = reqCallee ? ADDR_W'(CALLEE_BYTES) : ADDR_W'(BASIC_BYTES);
    framePtrNext = curSp - frameBytes;
    checksOn     = v8Profile && !(negPriority && ignoreOvf);
    overflow     = checksOn && (framePtrNext < selLimit);
  end

  // other-state stack pointer screening (R8-R10)
  always_comb begin
    otherUseProc = !handlerMode && otherSpSel;
    otherLim     = otherUseProc ? otherProcLimit : otherMainLimit;
    otherBelow   = otherWrVal < otherLim;
    otherOk      = otherWrValid && secureState && !otherBelow;
    otherBad     = otherWrValid && secureState && otherBelow;
  end

  assign lastWord = (idx == lastIdx);
  assign stAddr   = basePtr + (ADDR_W'(idx) * ADDR_W'(WORD_BYTES));
  assign stData   = frameReg[idx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      basePtr  <= '0;
      idx      <= '0;
      lastIdx  <= '0;
      frameReg <= '0;
    end else if (strobe.capture) begin
      basePtr  <= framePtrNext;
      idx      <= '0;
      lastIdx  <= reqCallee ? IDX_W'(CALLEE_WORDS - 1) : IDX_W'(BASIC_WORDS - 1);
      frameReg <= frameWords;
    end else if (strobe.advance && !lastWord) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spWe        <= 1'b0;
      spNew       <= '0;
      done        <= 1'b0;
      ovfPend     <= 1'b0;
      ovfBank     <= 1'b0;
      otherSpWe   <= 1'b0;
      otherSpProc <= 1'b0;
      otherSpData <= '0;
    end else begin
      spWe      <= strobe.clamp || strobe.finish;
      done      <= strobe.clamp || strobe.finish;
      ovfPend   <= strobe.clamp || otherBad;
      otherSpWe <= otherOk;
      if (strobe.clamp)       spNew <= selLimit;
      else if (strobe.finish) spNew <= basePtr;
      if (strobe.clamp || otherBad) ovfBank <= secureState;
      if (otherOk) begin
        otherSpProc <= otherUseProc;
        otherSpData <= otherWrVal;
      end
    end
  end

  // R1, R2: consecutive stores climb by one word
  assert_ascending_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !lastWord) |=> (stAddr == $past(stAddr) + ADDR_W'(WORD_BYTES)));

  // R11: address and data hold while the store waits
  assert_store_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pushing && !strobe.advance) |=> ($stable(stAddr) && $stable(stData)));

  // R4: a clamp reports the limit and raises the request
  assert_clamp_limit_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clamp |=> (spNew == $past(selLimit) && ovfPend && spWe));

  // R8: a forwarded write is never below its limit
  assert_other_in_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    otherWrValid |=> (!otherSpWe || otherSpData >= $past(otherLim)));

  // R10: only a secure requester can write the other pointer
  assert_other_secure_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    otherWrValid |=> (!otherSpWe || $past(secureState)));
endmodule

// File: rtl/stk_guard.sv
module stk_guard
  import stk_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int WORD_W       = 32,
  parameter int BASIC_WORDS  = 8,
  parameter int CALLEE_WORDS = 10
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           reqValid,
  input  logic                           reqCallee,
  output logic                           busy,
  input  logic [ADDR_W-1:0]              curSp,
  input  logic [ADDR_W-1:0]              mainLimit,
  input  logic [ADDR_W-1:0]              procLimit,
  input  logic                           handlerMode,
  input  logic                           spSel,
  input  logic                           tailChain,
  input  logic                           retModeThread,
  input  logic                           retSpSelProc,
  input  logic                           v8Profile,
  input  logic                           negPriority,
  input  logic                           ignoreOvf,
  input  logic                           secureState,
  input  logic [CALLEE_WORDS*WORD_W-1:0] frameWords,
  output logic                           stValid,
  input  logic                           stReady,
  output logic [ADDR_W-1:0]              stAddr,
  output logic [WORD_W-1:0]              stData,
  output logic                           spWe,
  output logic [ADDR_W-1:0]              spNew,
  output logic                           done,
  input  logic                           otherWrValid,
  input  logic [ADDR_W-1:0]              otherWrVal,
  input  logic                           otherSpSel,
  input  logic [ADDR_W-1:0]              otherMainLimit,
  input  logic [ADDR_W-1:0]              otherProcLimit,
  output logic                           otherSpWe,
  output logic                           otherSpProc,
  output logic [ADDR_W-1:0]              otherSpData,
  output logic                           ovfPend,
  output logic                           ovfBank
);
  stk_strobe_t strobe;
  logic        overflow, lastWord;

  stk_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .overflow (overflow),
    .lastWord (lastWord),
    .stReady  (stReady),
    .strobe   (strobe),
    .busy     (busy),
    .stValid  (stValid)
  );

  stk_dp #(
    .ADDR_W       (ADDR_W),
    .WORD_W       (WORD_W),
    .BASIC_WORDS  (BASIC_WORDS),
    .CALLEE_WORDS (CALLEE_WORDS)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .reqCallee      (reqCallee),
    .curSp          (curSp),
    .mainLimit      (mainLimit),
    .procLimit      (procLimit),
    .handlerMode    (handlerMode),
    .spSel          (spSel),
    .tailChain      (tailChain),
    .retModeThread  (retModeThread),
    .retSpSelProc   (retSpSelProc),
    .v8Profile      (v8Profile),
    .negPriority    (negPriority),
    .ignoreOvf      (ignoreOvf),
    .secureState    (secureState),
    .frameWords     (frameWords),
    .otherWrValid   (otherWrValid),
    .otherWrVal     (otherWrVal),
    .otherSpSel     (otherSpSel),
    .otherMainLimit (otherMainLimit),
    .otherProcLimit (otherProcLimit),
    .overflow       (overflow),
    .lastWord       (lastWord),
    .stAddr         (stAddr),
    .stData         (stData),
    .spWe           (spWe),
    .spNew          (spNew),
    .done           (done),
    .otherSpWe      (otherSpWe),
    .otherSpProc    (otherSpProc),
    .otherSpData    (otherSpData),
    .ovfPend        (ovfPend),
    .ovfBank        (ovfBank)
  );
endmodule

// File: tb/stk_guard_tb.sv
module stk_guard_tb;
  localparam int AW = 32;
  localparam int WW = 32;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqCallee = 0, busy;
  logic [AW-1:0] curSp = '0, mainLimit = 32'h2000_1000, procLimit = 32'h2000_3000;
  logic handlerMode = 0, spSel = 0, tailChain = 0, retModeThread = 0, retSpSelProc = 0;
  logic v8Profile = 0, negPriority = 0, ignoreOvf = 0, secureState = 0;
  logic [CW*WW-1:0] frameWords = '0;
  logic stValid, stReady = 0;
  logic [AW-1:0] stAddr;
  logic [WW-1:0] stData;
  logic spWe, done;
  logic [AW-1:0] spNew;
  logic otherWrValid = 0, otherSpSel = 0;
  logic [AW-1:0] otherWrVal = '0, otherMainLimit = 32'h3000_1000, otherProcLimit = 32'h3000_5000;
  logic otherSpWe, otherSpProc, ovfPend, ovfBank;
  logic [AW-1:0] otherSpData;

  int nChecks = 0;
  int nFail = 0;
  logic [7:0] lfsr = 8'h5b;

  always #4 clk = ~clk;

  stk_guard u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCallee(reqCallee), .busy(busy),
    .curSp(curSp), .mainLimit(mainLimit), .procLimit(procLimit),
    .handlerMode(handlerMode), .spSel(spSel), .tailChain(tailChain),
    .retModeThread(retModeThread), .retSpSelProc(retSpSelProc),
    .v8Profile(v8Profile), .negPriority(negPriority), .ignoreOvf(ignoreOvf),
    .secureState(secureState), .frameWords(frameWords),
    .stValid(stValid), .stReady(stReady), .stAddr(stAddr), .stData(stData),
    .spWe(spWe), .spNew(spNew), .done(done),
    .otherWrValid(otherWrValid), .otherWrVal(otherWrVal), .otherSpSel(otherSpSel),
    .otherMainLimit(otherMainLimit), .otherProcLimit(otherProcLimit),
    .otherSpWe(otherSpWe), .otherSpProc(otherSpProc), .otherSpData(otherSpData),
    .ovfPend(ovfPend), .ovfBank(ovfBank)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wordPat(input int run, input int i);
    return 32'hA500_0000 + 32'(run) * 32'h100 + 32'(i);
  endfunction

  function automatic bit nextReady();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    return lfsr[0] | lfsr[1];
  endfunction

  // one stacking request, from a negedge to the negedge after completion
  task automatic runStack(input int run, input bit kind, input bit tail, input bit hm, input bit ss,
                          input bit rm, input bit rs, input bit v8, input bit neg, input bit ign,
                          input bit sec, input int delta);
    bit useProc, checksOn, expOvf;
    logic [31:0] lim, fp, sz;
    int nW;
    string selTag, wTag;
    useProc  = (kind && tail) ? (rm && rs) : (!hm && ss);
    lim      = useProc ? procLimit : mainLimit;
    sz       = kind ? 32'h28 : 32'h20;
    nW       = kind ? 10 : 8;
    fp       = lim + 32'(delta);
    checksOn = v8 && !(neg && ign);
    expOvf   = checksOn && (delta < 0);
    selTag   = (kind && tail) ? "R6" : "R5";
    wTag     = kind ? "R2" : "R1";
    reqCallee = kind; tailChain = tail; handlerMode = hm; spSel = ss;
    retModeThread = rm; retSpSelProc = rs; v8Profile = v8; negPriority = neg;
    ignoreOvf = ign; secureState = sec; curSp = fp + sz;
    for (int i = 0; i < CW; i++) frameWords[32*i +: 32] = wordPat(run, i);
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (expOvf) begin
      chk(stValid == 1'b0, "R4 no store on overflow", 32'(stValid), 0);
      chk(spWe && done, "R4 sp update and done", {30'd0, spWe, done}, 3);
      chk(spNew == lim, selTag, spNew, lim);
      chk(ovfPend == 1'b1, "R4 pend", 32'(ovfPend), 1);
      chk(ovfBank == sec, "R4 bank", 32'(ovfBank), 32'(sec));
      @(negedge clk);
      chk(!ovfPend && !stValid && !busy, "R4 single pulse", {29'd0, ovfPend, stValid, busy}, 0);
    end else begin
      int idx = 0;
      while (idx < nW) begin
        chk(stValid && busy, "R11 store offered", {30'd0, stValid, busy}, 3);
        chk(stAddr == fp + 32'(4 * idx), wTag, stAddr, fp + 32'(4 * idx));
        chk(stData == wordPat(run, idx), wTag, stData, wordPat(run, idx));
        stReady = nextReady();
        @(posedge clk);
        if (stReady) idx++;
        @(negedge clk);
      end
      stReady = 1'b0;
      chk(spWe && done, "R3 done", {30'd0, spWe, done}, 3);
      chk(spNew == fp, (delta < 0) ? "R7 unchecked push" : selTag, spNew, fp);
      chk(ovfPend == 1'b0, "R3 no pend", 32'(ovfPend), 0);
      chk(stValid == 1'b0, "R11 port closes", 32'(stValid), 0);
    end
  endtask

  task automatic runOther(input bit sec, input bit hm, input bit os, input int delta);
    bit useProc, expOk, expBad;
    logic [31:0] lim, val;
    useProc = !hm && os;
    lim     = useProc ? otherProcLimit : otherMainLimit;
    val     = lim + 32'(delta);
    expOk   = sec && (delta >= 0);
    expBad  = sec && (delta < 0);
    secureState = sec; handlerMode = hm; otherSpSel = os;
    otherWrVal = val; otherWrValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    otherWrValid = 1'b0;
    chk(otherSpWe == expOk, sec ? (expOk ? "R8 write" : "R9 refuse") : "R10 ignored",
        32'(otherSpWe), 32'(expOk));
    chk(ovfPend == expBad, sec ? "R9 pend" : "R10 no pend", 32'(ovfPend), 32'(expBad));
    if (expOk) begin
      chk(otherSpData == val, "R8 data", otherSpData, val);
      chk(otherSpProc == useProc, "R8 target", 32'(otherSpProc), 32'(useProc));
    end
    if (expBad) chk(ovfBank == 1'b1, "R9 bank", 32'(ovfBank), 1);
    chk(spWe == 1'b0, "R10 no sp update", 32'(spWe), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    int run = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !stValid, "R11 reset idle", {30'd0, busy, stValid}, 0);
    chk(!spWe && !done, "R3 reset", {30'd0, spWe, done}, 0);
    chk(!ovfPend && !otherSpWe, "R4 reset", {30'd0, ovfPend, otherSpWe}, 0);

    // sweep of every mode combination at the limit boundary
    for (int m = 0; m < 1024; m++) begin
      for (int d = -1; d <= 1; d++) begin
        run++;
        runStack(run, m[0], m[1], m[2], m[3], m[4], m[5], m[6], m[7], m[8], m[9], 4 * d);
      end
    end

    // other-state stack pointer writes
    for (int m = 0; m < 8; m++)
      for (int d = -1; d <= 1; d++)
        runOther(m[0], m[1], m[2], 4 * d);

    // R11: a request while busy is ignored
    reqCallee = 0; tailChain = 0; handlerMode = 1; spSel = 0; v8Profile = 1;
    negPriority = 0; ignoreOvf = 0; secureState = 0;
    curSp = mainLimit + 32'h100;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    curSp = mainLimit;  // would overflow if taken
    repeat (3) @(negedge clk);
    chk(busy && ovfPend == 1'b0, "R11 busy ignores request", {30'd0, busy, ovfPend}, 2);
    reqValid = 1'b0;
    stReady = 1'b1;
    for (int i = 0; i < 8; i++) @(negedge clk);
    stReady = 1'b0;
    chk(spNew == mainLimit + 32'he0 && done, "R11 first request only", spNew, mainLimit + 32'he0);
    @(negedge clk);
    chk(!stValid && !busy, "R11 no second push", {30'd0, stValid, busy}, 0);

    // R12: stacking overflow and refused other write in the same cycle
    secureState = 1; handlerMode = 1; v8Profile = 1; reqCallee = 0; tailChain = 0;
    curSp = mainLimit + 32'h1c;
    otherWrVal = otherMainLimit - 32'h8;
    reqValid = 1'b1; otherWrValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; otherWrValid = 1'b0;
    chk(ovfPend && ovfBank, "R12 one pend secure bank", {30'd0, ovfPend, ovfBank}, 3);
    chk(spWe && spNew == mainLimit, "R12 clamp", spNew, mainLimit);
    chk(otherSpWe == 1'b0, "R12 refused", 32'(otherSpWe), 0);
    @(negedge clk);
    chk(ovfPend == 1'b0, "R12 single pulse", 32'(ovfPend), 0);

    // R12: overflow together with a legal other write
    curSp = mainLimit + 32'h1c;
    otherWrVal = otherMainLimit + 32'h40;
    reqValid = 1'b1; otherWrValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; otherWrValid = 1'b0;
    chk(ovfPend && otherSpWe, "R12 pend with legal write", {30'd0, ovfPend, otherSpWe}, 3);
    chk(otherSpData == otherMainLimit + 32'h40, "R12 write data", otherSpData, otherMainLimit + 32'h40);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule